// File: doc/BRIEF.md
# Text Overlay Generator

This block lays a page of text over a live video picture. It holds a character buffer of 16 rows by 31 columns. Each row also has one attribute byte, and that byte sets the look of the whole row. The block counts pixels from horizontal sync and lines from vertical sync. From those counts it produces digital red, green and blue outputs, plus an overlay enable that a downstream video switch uses for fast blanking between the picture and the overlay.

A host processor reaches the block through a four-register window selected by two address bits. It loads a buffer pointer, then streams bytes through a data register that advances the pointer after each access. A control register turns the display on and allows blinking. Each row's attributes select double height, underline, blink, a background colour of transparent, blue or black, and whether the characters cast a shadow or sit on a solid block. Text pixels are always white. Glyphs come from a small computed character generator inside the block.

Top module: `osd_overlay`

## Requirements
- R1: After reset the pointer reads 0, the control register reads 0 (display off), the frame counter is 0 and all four video outputs are low.
- R2: Register window on `bus_addr`: 0 = pointer bits 7:0, 1 = pointer bit 8 (in data bit 0), 2 = buffer data, 3 = control (bit 0 display on, bit 1 blink allowed; reads return the 2 bits zero-extended). A write or a read of register 2 moves the 9-bit pointer on by one, and the pointer wraps from 511 to 0.
- R3: Buffer entry `row*32 + col` holds the character code for columns 0 to 30. Entry `row*32 + 31` is the row attribute: bit 0 double height, bit 1 underline, bit 2 blink, bits 4:3 background (0 transparent, 1 blue, 2 or 3 black), bit 5 shadow (1) or block (0).
- R4: `hcnt` clears on every clock with `hsync` high and otherwise counts clocks. `vcnt` clears on a clock with `vsync` high and otherwise counts clocks with `hsync` high. The text window is hcnt 16..263 by vcnt 4..131 in cells 8 pixels wide and 8 lines tall. Outputs show the pixel of the previous clock's counts.
- R5: Code 0 is blank. For any other code, glyph line `l` (0..6) lights pixel `p` (0..4) of the cell when bit `4-p` of `code[4:0] ^ {l, l[1:0]}` is 1. Glyph line 7 and pixels 5..7 are unlit.
- R6: A text pixel drives red, green, blue and enable all high.
- R7: A window pixel that is neither text nor shadow shows the row background: blue gives enable and blue only, black gives enable only, transparent leaves enable low.
- R8: With underline set, all 8 pixels of glyph line 7 are text in every cell with a nonzero code.
- R9: Double height is honoured on even rows only. Such a row spans itself and the next row, showing glyph line `(k)/2` on pair line k (0..15). The odd row's characters and attributes are ignored.
- R10: The 6-bit frame counter advances on each clock with `vsync` high. With blink allowed, the text of blinking rows is hidden while counter bit 5 is 1. The background stays.
- R11: In shadow mode, a non-text window pixel whose up-left neighbour (x-1, y-1) is text is drawn black with enable high.
- R12: With the display off, or outside the window, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync | input | 1 | Horizontal sync pulse, active high |
| vsync | input | 1 | Vertical sync pulse, active high |
| bus_cs | input | 1 | Register access strobe, one access per clock |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| ovl_r | output | 1 | Overlay red |
| ovl_g | output | 1 | Overlay green |
| ovl_b | output | 1 | Overlay blue |
| ovl_en | output | 1 | Overlay enable (fast blanking) |

## Verification
The mixer is tried on whole scan lines of a buffer filled with random codes and random attribute bytes. A reference model computes every pixel, so these lines catch a wrong cell lookup, glyph bit order or priority between text, shadow and background. Directed rows then isolate one attribute at a time. A plain row is swept over all eight glyph lines to pin the font. Underline and double-height rows separate line-7 handling from line doubling and odd-row suppression. Shadow rows on blue and black backgrounds separate the shadow from the fill. A blinking row is scanned in both halves of the frame cycle, with blink allowed and with it blocked. The register window is checked for pointer wrap, the high pointer bit and reads that advance the pointer.

// File: rtl/osd_pkg.sv
`timescale 1ns/1ps
package osd_pkg;

   localparam int CELL_W     = 8;
   localparam int CELL_H     = 8;
   localparam int ROW_SLOTS  = 32;
   localparam int ATTR_SLOT  = 31;

   typedef struct packed {
      logic [1:0] rsvd;
      logic       shadow;
      logic [1:0] bg;
      logic       blink;
      logic       uline;
      logic       dbl;
   } row_attr_t;

   typedef enum logic [1:0] {
      REG_PTR_LO = 2'd0,
      REG_PTR_HI = 2'd1,
      REG_DATA   = 2'd2,
      REG_CTRL   = 2'd3
   } reg_sel_t;

   typedef struct packed {
      logic en;
      logic r;
      logic g;
      logic b;
   } pix_t;

   // Computed glyph line: 5 pixel bits, MSB is the leftmost pixel.
   function automatic logic [4:0] glyph_row(input logic [7:0] code, input logic [2:0] line);
      if (line == 3'd7) return 5'd0;
      return code[4:0] ^ {line, line[1:0]};
   endfunction

endpackage

// File: rtl/osd_timing.sv
`timescale 1ns/1ps
module osd_timing #(
   parameter int HCNT_W  = 10,
   parameter int VCNT_W  = 9,
   parameter int FRAME_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hsync,
   input  logic               vsync,
   output logic [HCNT_W-1:0]  hcnt_q,
   output logic [VCNT_W-1:0]  vcnt_q,
   output logic [FRAME_W-1:0] frame_q
);

   localparam logic [HCNT_W-1:0] H_MAX = '1;
   localparam logic [VCNT_W-1:0] V_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt_q  <= '0;
         vcnt_q  <= '0;
         frame_q <= '0;
      end else begin
         if (hsync)                hcnt_q <= '0;
         else if (hcnt_q != H_MAX) hcnt_q <= hcnt_q + 1'b1;

         if (vsync)                         vcnt_q <= '0;
         else if (hsync && vcnt_q != V_MAX) vcnt_q <= vcnt_q + 1'b1;

         if (vsync) frame_q <= frame_q + 1'b1;
      end
   end

endmodule

// File: rtl/osd_regs.sv
`timescale 1ns/1ps
module osd_regs
   import osd_pkg::*;
#(
   parameter int ROWS         = 16,
   parameter bit READ_ADVANCE = 1'b1,
   localparam int ENTRIES     = ROWS * ROW_SLOTS,
   localparam int PTR_W       = $clog2(ENTRIES),
   localparam int HI_W        = PTR_W - 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_cs,
   input  logic             bus_we,
   input  logic [1:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   output logic [PTR_W-1:0] ptr_q,
   output logic             disp_en,
   output logic             blink_en,
   output logic [7:0]       buf_q [ENTRIES]
);

   logic wr_hit, rd_adv;

   assign wr_hit = bus_cs && bus_we;

   generate
      if (READ_ADVANCE) begin : g_rd_adv
         assign rd_adv = bus_cs && !bus_we && (reg_sel_t'(bus_addr) == REG_DATA);
      end else begin : g_rd_hold
         assign rd_adv = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q    <= '0;
         disp_en  <= 1'b0;
         blink_en <= 1'b0;
      end else if (wr_hit) begin
         case (reg_sel_t'(bus_addr))
            REG_PTR_LO: ptr_q[7:0]       <= bus_wdata;
            REG_PTR_HI: ptr_q[PTR_W-1:8] <= bus_wdata[HI_W-1:0];
            REG_DATA:   ptr_q            <= ptr_q + 1'b1;
            REG_CTRL: begin
               disp_en  <= bus_wdata[0];
               blink_en <= bus_wdata[1];
            end
            default: ;
         endcase
      end else if (rd_adv) begin
         ptr_q <= ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_hit && reg_sel_t'(bus_addr) == REG_DATA) buf_q[ptr_q] <= bus_wdata;
   end

   always_comb begin
      bus_rdata = '0;
      case (reg_sel_t'(bus_addr))
         REG_PTR_LO: bus_rdata = ptr_q[7:0];
         REG_PTR_HI: bus_rdata = 8'(ptr_q[PTR_W-1:8]);
         REG_DATA:   bus_rdata = buf_q[ptr_q];
         REG_CTRL:   bus_rdata = {6'd0, blink_en, disp_en};
         default:    bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/osd_glyph_tap.sv
`timescale 1ns/1ps
module osd_glyph_tap
   import osd_pkg::*;
#(
   parameter int ROWS     = 16,
   localparam int ROW_W   = $clog2(ROWS),
   localparam int ENTRIES = ROWS * ROW_SLOTS
) (
   input  logic             valid,
   input  logic [4:0]       col,
   input  logic [2:0]       px,
   input  logic [ROW_W-1:0] row,
   input  logic [2:0]       ln,
   input  logic             blink_hide,
   input  logic [7:0]       buf_q [ENTRIES],
   output logic             lit,
   output row_attr_t        attr
);

   logic [ROW_W-1:0] row_even, own;
   logic [2:0]       fline;
   row_attr_t        pair_attr;
   logic [7:0]       code;
   logic [4:0]       pattern;
   logic [7:0]       shifted;
   logic             face, rule;

   always_comb begin
      row_even  = {row[ROW_W-1:1], 1'b0};
      pair_attr = row_attr_t'(buf_q[{row_even, 5'(ATTR_SLOT)}]);
      if (pair_attr.dbl) begin
         own   = row_even;
         fline = {row[0], ln[2:1]};
      end else begin
         own   = row;
         fline = ln;
      end
      attr    = row_attr_t'(buf_q[{own, 5'(ATTR_SLOT)}]);
      code    = buf_q[{own, col}];
      pattern = glyph_row(code, fline);
      shifted = {3'd0, pattern} << px;
      face    = shifted[4];
      rule    = attr.uline && (fline == 3'd7);
      lit     = valid && (code != 8'd0) && !(attr.blink && blink_hide) && (face || rule);
   end

endmodule

// File: rtl/osd_overlay.sv
`timescale 1ns/1ps
module osd_overlay
   import osd_pkg::*;
#(
   parameter int ROWS         = 16,
   parameter int COLS         = 31,
   parameter int H_START      = 16,
   parameter int V_START      = 4,
   parameter int HCNT_W       = 10,
   parameter int VCNT_W       = 9,
   parameter int FRAME_W      = 6,
   parameter bit SHADOW_EN    = 1'b1,
   parameter bit READ_ADVANCE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hsync,
   input  logic       vsync,
   input  logic       bus_cs,
   input  logic       bus_we,
   input  logic [1:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       ovl_r,
   output logic       ovl_g,
   output logic       ovl_b,
   output logic       ovl_en
);

   localparam int ACT_W   = COLS * CELL_W;
   localparam int ACT_H   = ROWS * CELL_H;
   localparam int XW      = $clog2(ACT_W);
   localparam int ROW_W   = $clog2(ROWS);
   localparam int YW      = ROW_W + 3;
   localparam int ENTRIES = ROWS * ROW_SLOTS;
   localparam int PTR_W   = $clog2(ENTRIES);

   localparam logic [HCNT_W-1:0] H_LO = HCNT_W'(H_START);
   localparam logic [HCNT_W-1:0] H_HI = HCNT_W'(H_START + ACT_W);
   localparam logic [VCNT_W-1:0] V_LO = VCNT_W'(V_START);
   localparam logic [VCNT_W-1:0] V_HI = VCNT_W'(V_START + ACT_H);

   generate
      if (COLS < 1 || COLS > ATTR_SLOT)
         $error("COLS must leave slot 31 of each row for the attribute");
      if (ROWS < 16 || ROWS > 128 || (1 << ROW_W) != ROWS)
         $error("ROWS must be a power of two from 16 to 128");
      if (H_START + ACT_W >= (1 << HCNT_W) || V_START + ACT_H >= (1 << VCNT_W))
         $error("counter widths too small for the text window");
      if (H_START < 1 || V_START < 1)
         $error("window must start after the sync position");
   endgenerate

   logic [HCNT_W-1:0]  hcnt_q;
   logic [VCNT_W-1:0]  vcnt_q;
   logic [FRAME_W-1:0] frame_q;
   logic [PTR_W-1:0]   ptr_q;
   logic               disp_en, blink_en, blink_hide;
   logic [7:0]         buf_q [ENTRIES];

   osd_timing #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .FRAME_W(FRAME_W)) u_timing (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
      .hcnt_q(hcnt_q), .vcnt_q(vcnt_q), .frame_q(frame_q)
   );

   osd_regs #(.ROWS(ROWS), .READ_ADVANCE(READ_ADVANCE)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ptr_q(ptr_q), .disp_en(disp_en), .blink_en(blink_en), .buf_q(buf_q)
   );

   assign blink_hide = blink_en && frame_q[FRAME_W-1];

   logic          in_x, in_y, in_win, sh_ok;
   logic [XW-1:0] x_cur, x_prv;
   logic [YW-1:0] y_cur, y_prv;

   assign in_x   = (hcnt_q >= H_LO) && (hcnt_q < H_HI);
   assign in_y   = (vcnt_q >= V_LO) && (vcnt_q < V_HI);
   assign in_win = in_x && in_y;
   assign sh_ok  = in_win && (hcnt_q > H_LO) && (vcnt_q > V_LO);
   assign x_cur  = XW'(hcnt_q - H_LO);
   assign y_cur  = YW'(vcnt_q - V_LO);
   assign x_prv  = x_cur - 1'b1;
   assign y_prv  = y_cur - 1'b1;

   logic      cur_lit, sh_lit;
   row_attr_t cur_attr;

   osd_glyph_tap #(.ROWS(ROWS)) u_tap_cur (
      .valid(in_win), .col(5'(x_cur[XW-1:3])), .px(x_cur[2:0]),
      .row(y_cur[YW-1:3]), .ln(y_cur[2:0]), .blink_hide(blink_hide),
      .buf_q(buf_q), .lit(cur_lit), .attr(cur_attr)
   );

   generate
      if (SHADOW_EN) begin : g_shadow
         row_attr_t prv_attr;
         osd_glyph_tap #(.ROWS(ROWS)) u_tap_prv (
            .valid(sh_ok), .col(5'(x_prv[XW-1:3])), .px(x_prv[2:0]),
            .row(y_prv[YW-1:3]), .ln(y_prv[2:0]), .blink_hide(blink_hide),
            .buf_q(buf_q), .lit(sh_lit), .attr(prv_attr)
         );
      end else begin : g_no_shadow
         assign sh_lit = 1'b0;
      end
   endgenerate

   pix_t pix_d, pix_q;

   always_comb begin
      pix_d = '0;
      if (disp_en && in_win) begin
         if (cur_lit)                          pix_d = '{en: 1'b1, r: 1'b1, g: 1'b1, b: 1'b1};
         else if (cur_attr.shadow && sh_lit)   pix_d = '{en: 1'b1, r: 1'b0, g: 1'b0, b: 1'b0};
         else begin
            case (cur_attr.bg)
               2'd1:       pix_d = '{en: 1'b1, r: 1'b0, g: 1'b0, b: 1'b1};
               2'd2, 2'd3: pix_d = '{en: 1'b1, r: 1'b0, g: 1'b0, b: 1'b0};
               default:    pix_d = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pix_q <= '0;
      else        pix_q <= pix_d;
   end

   assign ovl_en = pix_q.en;
   assign ovl_r  = pix_q.r;
   assign ovl_g  = pix_q.g;
   assign ovl_b  = pix_q.b;

endmodule

// File: rtl/osd_overlay_chk.sv
`timescale 1ns/1ps
module osd_overlay_chk #(
   parameter int HCNT_W  = 10,
   parameter int FRAME_W = 6,
   parameter int PTR_W   = 9,
   parameter int H_START = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               hsync,
   input logic               vsync,
   input logic               bus_cs,
   input logic               bus_we,
   input logic [1:0]         bus_addr,
   input logic               ovl_r,
   input logic               ovl_g,
   input logic               ovl_b,
   input logic               ovl_en,
   input logic               disp_en,
   input logic [HCNT_W-1:0]  hcnt_q,
   input logic [FRAME_W-1:0] frame_q,
   input logic [PTR_W-1:0]   ptr_q
);

   AST_HOME_ON_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
      hsync |=> (hcnt_q == '0)); // R4

   AST_DARK_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      (hcnt_q < HCNT_W'(H_START)) |=> !ovl_en); // R12

   AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_en |=> (!ovl_en && !ovl_r && !ovl_g && !ovl_b)); // R12

   AST_WHITE_TEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (ovl_r || ovl_g) |-> (ovl_r && ovl_g && ovl_b && ovl_en)); // R6

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs && bus_we && bus_addr == 2'd2) |=> (ptr_q == $past(ptr_q) + 1'b1)); // R2

   AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |=> (frame_q == $past(frame_q) + 1'b1)); // R10

endmodule

bind osd_overlay osd_overlay_chk #(
   .HCNT_W(HCNT_W), .FRAME_W(FRAME_W), .PTR_W(PTR_W), .H_START(H_START)
) u_chk (
   .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
   .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
   .ovl_r(ovl_r), .ovl_g(ovl_g), .ovl_b(ovl_b), .ovl_en(ovl_en),
   .disp_en(disp_en), .hcnt_q(hcnt_q), .frame_q(frame_q), .ptr_q(ptr_q)
);

// File: tb/test_osd_overlay.sv
`timescale 1ns/1ps
module test_osd_overlay;

   localparam int H0 = 16;
   localparam int V0 = 4;
   localparam int AW = 248;
   localparam int AH = 128;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hsync = 1'b0, vsync = 1'b0;
   logic       bus_cs = 1'b0, bus_we = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       ovl_r, ovl_g, ovl_b, ovl_en;

   int tests = 0, fails = 0;
   bit done = 1'b0;

   logic [7:0] mem_m [512];
   logic [1:0] ctrl_m = 2'd0;
   int         ptr_m = 0;
   int         fc_m = 0;

   always #5 clk = ~clk;

   osd_overlay i_osd_overlay (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
      .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ovl_r(ovl_r), .ovl_g(ovl_g), .ovl_b(ovl_b), .ovl_en(ovl_en)
   );

   task automatic check(input string req, input string what, input int got, input int exp);
      tests++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
      end
   endtask

   task automatic wreg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_cs = 1'b0; bus_we = 1'b0;
      case (a)
         2'd0: ptr_m = (ptr_m & 256) | int'(d);
         2'd1: ptr_m = (ptr_m & 255) | (int'(d[0]) << 8);
         2'd2: begin mem_m[ptr_m] = d; ptr_m = (ptr_m + 1) % 512; end
         default: ctrl_m = d[1:0];
      endcase
   endtask

   task automatic rreg(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_cs = 1'b0;
      if (a == 2'd2) ptr_m = (ptr_m + 1) % 512;
   endtask

   task automatic put(input int idx, input logic [7:0] v);
      wreg(2'd0, 8'(idx));
      wreg(2'd1, 8'(idx >> 8));
      wreg(2'd2, v);
   endtask

   task automatic advance(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); vsync = 1'b1;
         @(negedge clk); vsync = 1'b0;
         fc_m++;
      end
   endtask

   function automatic int owner_row(input int y, output int fl);
      int r, l, top;
      r = y / 8; l = y % 8; top = r - (r % 2);
      if (mem_m[top * 32 + 31][0]) begin
         fl = ((r % 2) * 8 + l) / 2;
         return top;
      end
      fl = l;
      return r;
   endfunction

   function automatic bit txt_at(input int x, input int y);
      int own, fl, p, pat;
      logic [7:0] a, code;
      own  = owner_row(y, fl);
      a    = mem_m[own * 32 + 31];
      code = mem_m[own * 32 + x / 8];
      if (code == 8'd0) return 1'b0;
      if (a[2] && ctrl_m[1] && (fc_m % 64) >= 32) return 1'b0;
      p = x % 8;
      if (a[1] && fl == 7) return 1'b1;
      if (p >= 5 || fl == 7) return 1'b0;
      pat = int'(code[4:0]) ^ (fl * 4 + fl % 4);
      return ((pat >> (4 - p)) & 1) != 0;
   endfunction

   function automatic logic [3:0] exp_pix(input int h, input int v);
      int x, y, fl, own;
      logic [7:0] a;
      if (!ctrl_m[0]) return 4'b0000;
      x = h - H0; y = v - V0;
      if (x < 0 || x >= AW || y < 0 || y >= AH) return 4'b0000;
      if (txt_at(x, y)) return 4'b1111;
      own = owner_row(y, fl);
      a = mem_m[own * 32 + 31];
      if (a[5] && x >= 1 && y >= 1 && txt_at(x - 1, y - 1)) return 4'b1000;
      case (a[4:3])
         2'd1:    return 4'b1001;
         2'd2:    return 4'b1000;
         2'd3:    return 4'b1000;
         default: return 4'b0000;
      endcase
   endfunction

   // Scan one line at vcnt = vline and compare every pixel; one check per line.
   task automatic scan(input string req, input int vline);
      int bad, first_h;
      logic [3:0] got, exp, g1, e1;
      @(negedge clk); vsync = 1'b1; hsync = 1'b1;
      fc_m++;
      for (int i = 0; i < vline; i++) begin
         @(negedge clk); vsync = 1'b0; hsync = 1'b1;
      end
      @(negedge clk); vsync = 1'b0; hsync = 1'b0;
      bad = 0; first_h = -1; g1 = '0; e1 = '0;
      for (int j = 0; j < H0 + AW + 4; j++) begin
         @(negedge clk);
         got = {ovl_en, ovl_r, ovl_g, ovl_b};
         exp = exp_pix(j, vline);
         if (got !== exp) begin
            if (bad == 0) begin first_h = j; g1 = got; e1 = exp; end
            bad++;
         end
      end
      tests++;
      if (bad != 0) begin
         fails++;
         $display("FAIL %s line %0d: %0d bad pixels, first at hcnt %0d got %b expected %b",
                  req, vline, bad, first_h, g1, e1);
      end
   endtask

   initial begin
      #1_900_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1", "outputs", int'({ovl_en, ovl_r, ovl_g, ovl_b}), 0);
      rreg(2'd0, d); check("R1", "ptr lo", int'(d), 0);
      rreg(2'd1, d); check("R1", "ptr hi", int'(d), 0);
      rreg(2'd3, d); check("R1", "ctrl", int'(d), 0);

      // R2 register window
      wreg(2'd0, 8'hAB); wreg(2'd1, 8'h01);
      rreg(2'd0, d); check("R2", "ptr lo readback", int'(d), 'hAB);
      rreg(2'd1, d); check("R2", "ptr hi readback", int'(d), 1);
      put(511, 8'h5A);
      rreg(2'd0, d); check("R2", "ptr wrap lo", int'(d), 0);
      rreg(2'd1, d); check("R2", "ptr wrap hi", int'(d), 0);
      wreg(2'd0, 8'hFF); wreg(2'd1, 8'h01);
      rreg(2'd2, d); check("R2", "data read", int'(d), 'h5A);
      rreg(2'd0, d); check("R2", "read advances ptr", int'(d), 0);
      wreg(2'd3, 8'hFC);
      rreg(2'd3, d); check("R2", "ctrl masks bits", int'(d), 0);
      wreg(2'd3, 8'hFF);
      rreg(2'd3, d); check("R2", "ctrl readback", int'(d), 3);
      wreg(2'd3, 8'h00);

      // R3 random page streamed through the data register
      wreg(2'd0, 8'h00); wreg(2'd1, 8'h00);
      for (int i = 0; i < 512; i++) begin
         if (i % 32 == 31) wreg(2'd2, 8'($urandom));
         else wreg(2'd2, ($urandom % 4 == 0) ? 8'd0 : 8'($urandom));
      end
      put(37, 8'h3C);
      wreg(2'd0, 8'd37); wreg(2'd1, 8'd0);
      rreg(2'd2, d); check("R3", "buffer readback", int'(d), 'h3C);

      // R12 display off
      scan("R12", V0 + 40);
      wreg(2'd3, 8'h01);
      for (int i = 0; i < 12; i++) scan("R4", V0 + int'($urandom % AH));
      scan("R12", 2);
      scan("R12", V0 + AH + 1);

      // R5 plain row 0 with a letter run
      put(31, 8'h00);
      put(63, 8'h00);
      for (int c = 0; c < 31; c++) put(c, 8'h41 + 8'(c));
      put(5, 8'h00);
      for (int l = 0; l < 8; l++) scan("R5", V0 + l);

      // R8 underline on row 2
      put(2 * 32 + 31, 8'h02);
      put(2 * 32 + 4, 8'h00);
      scan("R8", V0 + 23);
      scan("R8", V0 + 20);

      // R9 double height row 4, row 5 suppressed
      put(4 * 32 + 31, 8'h01);
      put(5 * 32 + 31, 8'h0A);
      for (int c = 0; c < 31; c++) put(5 * 32 + c, 8'h7F);
      scan("R9", V0 + 33);
      scan("R9", V0 + 38);
      scan("R9", V0 + 41);
      scan("R9", V0 + 47);

      // R11 shadow on blue and on black
      put(6 * 32 + 31, 8'h28);
      put(7 * 32 + 31, 8'h30);
      for (int l = 48; l < 52; l++) scan("R11", V0 + l);
      scan("R11", V0 + 56);

      // R7 backgrounds: black block, transparent, code 3
      put(8 * 32 + 31, 8'h10);
      put(9 * 32 + 31, 8'h00);
      put(10 * 32 + 31, 8'h18);
      scan("R7", V0 + 66);
      scan("R7", V0 + 74);
      scan("R7", V0 + 82);
      scan("R6", V0 + 3);

      // R10 blinking row 12
      put(12 * 32 + 31, 8'h04);
      for (int c = 0; c < 31; c++) put(12 * 32 + c, 8'h55);
      wreg(2'd3, 8'h03);
      advance((64 - fc_m % 64) % 64);
      scan("R10", V0 + 97);
      advance(39);
      scan("R10", V0 + 97);
      wreg(2'd3, 8'h01);
      scan("R10", V0 + 98);
      wreg(2'd3, 8'h03);

      // mixed random lines over the edited page
      for (int i = 0; i < 10; i++) scan("R3", V0 + int'($urandom % AH));

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule